// File: doc/BRIEF.md
# Indexed-Command GPIO Controller

This block is an APB slave that owns a bank of general-purpose pins. It synchronises the pin input levels into the clock domain, keeps one output level and one 2-bit mode per pin, and turns each pin's mode into a direction bit. Software can load every output level at once with a whole-word write. It can also change a single pin by writing that pin's number to a set, clear or invert command.

A stored pin index selects one pin. A single read of the status word then returns that pin's mode, interrupt configuration, synchronised input level and output level, along with the index itself. The index is written directly, and it is also updated as a side effect of the single-pin commands and of the interrupt-configuration command. This block only stores the interrupt configuration. It does not detect interrupts.

The slave has no wait states. A write takes effect on the clock edge at which select, enable and write are all high. Pin numbers at or above the pin count are accepted on the bus, but they change no pin state.

Top module: `gpio_idx_apb`

## Requirements
- R1: After reset, `gpio_out_o` and `gpio_dir_o` are all zero, the stored index is 0, and every pin is in input mode (mode 00) with interrupt type 0 and interrupt enable 0.
- R2: A write to offset 0x00 sets the output of the pin numbered by data bits [7:0] to 1. It is visible on `gpio_out_o` after that access edge, and no other pin changes.
- R3: A write to offset 0x04 clears the output of the pin numbered by data bits [7:0] to 0, and no other pin changes.
- R4: A write to offset 0x08 inverts the output of the pin numbered by data bits [7:0], and no other pin changes.
- R5: A pin number of 32 or above in data bits [7:0] leaves all outputs, modes and interrupt settings unchanged on a set, clear, invert, mode or interrupt-configuration write. The stored index still takes the value where the command updates it.
- R6: A read of offset 0x10 returns the input levels of pins 31..0 through a two-flop synchroniser. A change on `gpio_i` is first returned by a read whose access edge falls at least two clock edges after the change.
- R7: A write to offset 0x20 loads all 32 output levels from the write data in one edge.
- R8: A write to offset 0x30 stores data bits [7:0] as the index. Writes to 0x00, 0x04, 0x08 and 0x3C also store their data bits [7:0]. No other access changes the index.
- R9: A read of offset 0x34 returns the indexed pin's status: mode in [25:24], interrupt type in [19:17], interrupt enable in [16], synchronised input in [12], output in [8], and the index in [7:0]. All other bits are 0. For an index of 32 or above, only [7:0] is non-zero.
- R10: A write to offset 0x38 sets the mode of the pin numbered by data [7:0] to data [25:24]. Mode 01 means output, so that pin's `gpio_dir_o` bit is 1. Modes 00, 10 and 11 mean input, so the bit is 0.
- R11: A write to offset 0x3C stores data [19:17] as the interrupt type and data [16] as the interrupt enable of the pin numbered by data [7:0].
- R12: A read of any offset other than 0x10 and 0x34 returns 0. A cycle with PSEL and PWRITE high but PENABLE low changes nothing. PREADY is always 1 and PSLVERR is always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| psel_i | input | 1 | APB select |
| penable_i | input | 1 | APB enable (access phase) |
| pwrite_i | input | 1 | APB write strobe |
| paddr_i | input | ADDR_W (8) | APB byte address |
| pwdata_i | input | 32 | APB write data |
| prdata_o | output | 32 | APB read data |
| pready_o | output | 1 | Always 1 |
| pslverr_o | output | 1 | Always 0 |
| gpio_i | input | NPINS (32) | Pin input levels, asynchronous |
| gpio_out_o | output | NPINS (32) | Pin output levels |
| gpio_dir_o | output | NPINS (32) | Per-pin direction, 1 = drive |

## Verification
The bench uses the default parameters: 32 pins, an 8-bit index, an 8-bit address and two synchroniser stages. With an 8-bit index and only 32 pins, pin numbers 32 through 255 can be put on the bus, so random commands include numbers up to 39 and exercise the ignore path next to the valid range. With two stages, the bench starts a read on the same edge as an input change and expects the old value. It then expects the new value on the following read.

// File: rtl/gpio_idx_pkg.sv
package gpio_idx_pkg;
  typedef enum logic [1:0] {
    MODE_IN   = 2'b00,
    MODE_OUT  = 2'b01,
    MODE_RSV2 = 2'b10,
    MODE_RSV3 = 2'b11
  } pin_mode_e;

  localparam logic [7:0] OFF_SET  = 8'h00;
  localparam logic [7:0] OFF_CLR  = 8'h04;
  localparam logic [7:0] OFF_TOG  = 8'h08;
  localparam logic [7:0] OFF_PIN  = 8'h10;
  localparam logic [7:0] OFF_WORD = 8'h20;
  localparam logic [7:0] OFF_SEL  = 8'h30;
  localparam logic [7:0] OFF_STAT = 8'h34;
  localparam logic [7:0] OFF_MODE = 8'h38;
  localparam logic [7:0] OFF_INT  = 8'h3C;

  // field positions shared by command data and status word
  localparam int MODE_LSB  = 24;
  localparam int ITYPE_LSB = 17;
  localparam int ITYPE_W   = 3;
  localparam int IEN_BIT   = 16;
  localparam int IN_BIT    = 12;
  localparam int OUT_BIT   = 8;

  typedef struct packed {
    logic word_wr;
    logic set_wr;
    logic clr_wr;
    logic tog_wr;
    logic sel_wr;
    logic mode_wr;
    logic int_wr;
  } gpio_cmd_t;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] chain_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q[s] <= '0;
      else if (s == 0) chain_q[s] <= d_i;
      else chain_q[s] <= chain_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = chain_q[STAGES-1];

  // edges since reset, saturating: guards the latency check
  localparam int CW = $clog2(STAGES+1) + 1;
  logic [CW-1:0] age_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) age_q <= '0;
    else if (age_q != CW'(STAGES)) age_q <= age_q + 1'b1;
  end

  assert_sync_latency_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q == CW'(STAGES)) |-> (q_o == $past(d_i, STAGES)));
endmodule

// File: rtl/gpio_pin_bank.sv
module gpio_pin_bank
  import gpio_idx_pkg::*;
#(
  parameter int NPINS = 32,
  parameter int IDX_W = 8
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  gpio_cmd_t                        cmd_i,
  input  logic [31:0]                      wdata_i,
  output logic [NPINS-1:0]                 out_o,
  output logic [NPINS-1:0]                 dir_o,
  output logic [NPINS-1:0][1:0]            mode_o,
  output logic [NPINS-1:0][ITYPE_W-1:0]    itype_o,
  output logic [NPINS-1:0]                 ien_o
);
  localparam int PIN_W = $clog2(NPINS);
  localparam logic [IDX_W:0] NPINS_X = (IDX_W+1)'(NPINS);

  logic [IDX_W-1:0] num;
  logic [PIN_W-1:0] pin;
  logic             in_range;
  logic [NPINS-1:0] out_q;

  assign num      = wdata_i[IDX_W-1:0];
  assign pin      = num[PIN_W-1:0];
  assign in_range = {1'b0, num} < NPINS_X;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) out_q <= '0;
    else if (cmd_i.word_wr) out_q <= wdata_i[NPINS-1:0];
    else if (in_range) begin
      if (cmd_i.set_wr) out_q[pin] <= 1'b1;
      else if (cmd_i.clr_wr) out_q[pin] <= 1'b0;
      else if (cmd_i.tog_wr) out_q[pin] <= ~out_q[pin];
    end
  end
  assign out_o = out_q;

  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    pin_mode_e          mode_q;
    logic [ITYPE_W-1:0] itype_q;
    logic               ien_q;
    logic               hit;
    assign hit = in_range && (pin == PIN_W'(p));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        mode_q  <= MODE_IN;
        itype_q <= '0;
        ien_q   <= 1'b0;
      end else begin
        if (cmd_i.mode_wr && hit) mode_q <= pin_mode_e'(wdata_i[MODE_LSB +: 2]);
        if (cmd_i.int_wr && hit) begin
          itype_q <= wdata_i[ITYPE_LSB +: ITYPE_W];
          ien_q   <= wdata_i[IEN_BIT];
        end
      end
    end

    assign mode_o[p]  = mode_q;
    assign itype_o[p] = itype_q;
    assign ien_o[p]   = ien_q;
    assign dir_o[p]   = (mode_q == MODE_OUT);
  end

  // assertion helper: pin number of the previous cycle
  logic [PIN_W-1:0] pin_d;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pin_d <= '0;
    else pin_d <= pin;
  end

  assert_set_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i.set_wr && in_range) |=> out_o[pin_d]);
  assert_clr_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i.clr_wr && in_range) |=> !out_o[pin_d]);
  assert_tog_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i.tog_wr && in_range) |=> (out_o[pin_d] != $past(out_o[pin])));
  assert_oor_ignored_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((cmd_i.set_wr || cmd_i.clr_wr || cmd_i.tog_wr || cmd_i.mode_wr || cmd_i.int_wr) && !in_range)
    |=> ($stable(out_o) && $stable(mode_o) && $stable(itype_o) && $stable(ien_o)));
  assert_word_load_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_i.word_wr |=> (out_o == $past(wdata_i[NPINS-1:0])));
  assert_dir_out_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i.mode_wr && in_range && wdata_i[MODE_LSB +: 2] == 2'b01) |=> dir_o[pin_d]);
  assert_dir_in_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i.mode_wr && in_range && wdata_i[MODE_LSB +: 2] != 2'b01) |=> !dir_o[pin_d]);
  assert_int_cfg_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i.int_wr && in_range) |=> (ien_o[pin_d] == $past(wdata_i[IEN_BIT])));
endmodule

// File: rtl/gpio_stat_mux.sv
module gpio_stat_mux
  import gpio_idx_pkg::*;
#(
  parameter int NPINS = 32,
  parameter int IDX_W = 8
) (
  input  logic [IDX_W-1:0]              idx_i,
  input  logic [NPINS-1:0]              in_i,
  input  logic [NPINS-1:0]              out_i,
  input  logic [NPINS-1:0][1:0]         mode_i,
  input  logic [NPINS-1:0][ITYPE_W-1:0] itype_i,
  input  logic [NPINS-1:0]              ien_i,
  output logic [31:0]                   stat_o
);
  localparam int PIN_W = $clog2(NPINS);
  localparam logic [IDX_W:0] NPINS_X = (IDX_W+1)'(NPINS);

  logic [PIN_W-1:0] pin;
  assign pin = idx_i[PIN_W-1:0];

  always_comb begin
    stat_o = '0;
    stat_o[IDX_W-1:0] = idx_i;
    if ({1'b0, idx_i} < NPINS_X) begin
      stat_o[MODE_LSB +: 2]        = mode_i[pin];
      stat_o[ITYPE_LSB +: ITYPE_W] = itype_i[pin];
      stat_o[IEN_BIT]              = ien_i[pin];
      stat_o[IN_BIT]               = in_i[pin];
      stat_o[OUT_BIT]              = out_i[pin];
    end
  end
endmodule

// File: rtl/gpio_idx_apb.sv
module gpio_idx_apb
  import gpio_idx_pkg::*;
#(
  parameter int NPINS       = 32,
  parameter int IDX_W       = 8,
  parameter int ADDR_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              psel_i,
  input  logic              penable_i,
  input  logic              pwrite_i,
  input  logic [ADDR_W-1:0] paddr_i,
  input  logic [31:0]       pwdata_i,
  output logic [31:0]       prdata_o,
  output logic              pready_o,
  output logic              pslverr_o,
  input  logic [NPINS-1:0]  gpio_i,
  output logic [NPINS-1:0]  gpio_out_o,
  output logic [NPINS-1:0]  gpio_dir_o
);
  logic                         wr_en;
  logic                         rd_en;
  gpio_cmd_t                    cmd;
  logic                         idx_upd;
  logic [IDX_W-1:0]             idx_q;
  logic [NPINS-1:0]             in_sync;
  logic [NPINS-1:0][1:0]        mode;
  logic [NPINS-1:0][ITYPE_W-1:0] itype;
  logic [NPINS-1:0]             ien;
  logic [31:0]                  stat;

  assign wr_en = psel_i && penable_i && pwrite_i;
  assign rd_en = psel_i && !pwrite_i;

  always_comb begin
    cmd         = '0;
    cmd.set_wr  = wr_en && (paddr_i == ADDR_W'(OFF_SET));
    cmd.clr_wr  = wr_en && (paddr_i == ADDR_W'(OFF_CLR));
    cmd.tog_wr  = wr_en && (paddr_i == ADDR_W'(OFF_TOG));
    cmd.word_wr = wr_en && (paddr_i == ADDR_W'(OFF_WORD));
    cmd.sel_wr  = wr_en && (paddr_i == ADDR_W'(OFF_SEL));
    cmd.mode_wr = wr_en && (paddr_i == ADDR_W'(OFF_MODE));
    cmd.int_wr  = wr_en && (paddr_i == ADDR_W'(OFF_INT));
  end

  assign idx_upd = cmd.sel_wr || cmd.set_wr || cmd.clr_wr || cmd.tog_wr || cmd.int_wr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) idx_q <= '0;
    else if (idx_upd) idx_q <= pwdata_i[IDX_W-1:0];
  end

  gpio_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (gpio_i),
    .q_o   (in_sync)
  );

  gpio_pin_bank #(.NPINS(NPINS), .IDX_W(IDX_W)) u_bank (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cmd_i  (cmd),
    .wdata_i(pwdata_i),
    .out_o  (gpio_out_o),
    .dir_o  (gpio_dir_o),
    .mode_o (mode),
    .itype_o(itype),
    .ien_o  (ien)
  );

  gpio_stat_mux #(.NPINS(NPINS), .IDX_W(IDX_W)) u_stat (
    .idx_i  (idx_q),
    .in_i   (in_sync),
    .out_i  (gpio_out_o),
    .mode_i (mode),
    .itype_i(itype),
    .ien_i  (ien),
    .stat_o (stat)
  );

  always_comb begin
    prdata_o = '0;
    if (rd_en) begin
      if (paddr_i == ADDR_W'(OFF_PIN)) prdata_o = 32'(in_sync);
      else if (paddr_i == ADDR_W'(OFF_STAT)) prdata_o = stat;
    end
  end

  assign pready_o  = 1'b1;
  assign pslverr_o = 1'b0;

  assert_idx_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !idx_upd |=> $stable(idx_q));
  assert_idx_load_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd.sel_wr |=> (idx_q == $past(pwdata_i[IDX_W-1:0])));
  assert_no_setup_write_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (psel_i && !penable_i) |=> ($stable(gpio_out_o) && $stable(gpio_dir_o) && $stable(idx_q)));
endmodule

// File: tb/tb_gpio_idx_apb.sv
`timescale 1ns/1ps
module tb_gpio_idx_apb;
  localparam int NP = 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [7:0]  paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic        pready, pslverr;
  logic [NP-1:0] gpio_in = '0;
  logic [NP-1:0] gpio_out, gpio_dir;

  always #2.5 clk = ~clk;

  gpio_idx_apb dut (
    .clk_i(clk), .rst_ni(rst_n), .psel_i(psel), .penable_i(penable), .pwrite_i(pwrite),
    .paddr_i(paddr), .pwdata_i(pwdata), .prdata_o(prdata), .pready_o(pready),
    .pslverr_o(pslverr), .gpio_i(gpio_in), .gpio_out_o(gpio_out), .gpio_dir_o(gpio_dir)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  logic [31:0] m_out = '0, m_in = '0;
  logic [1:0]  m_mode [NP];
  logic [2:0]  m_itype [NP];
  logic        m_ien [NP];
  logic [7:0]  m_idx = '0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] dir_exp();
    logic [31:0] d = '0;
    for (int i = 0; i < NP; i++) d[i] = (m_mode[i] == 2'b01);
    return d;
  endfunction

  function automatic logic [31:0] stat_exp(input logic [7:0] i);
    logic [31:0] s = 32'(i);
    if (i < 8'(NP)) begin
      s |= 32'(m_mode[i[4:0]]) << 24;
      s |= 32'(m_itype[i[4:0]]) << 17;
      s |= 32'(m_ien[i[4:0]]) << 16;
      s |= 32'(m_in[i[4:0]]) << 12;
      s |= 32'(m_out[i[4:0]]) << 8;
    end
    return s;
  endfunction

  // called at a negedge, returns at a negedge
  task automatic apb_wr(input logic [7:0] a, input logic [31:0] d);
    psel = 1; pwrite = 1; penable = 0; paddr = a; pwdata = d;
    @(negedge clk) penable = 1;
    @(negedge clk) begin psel = 0; penable = 0; pwrite = 0; end
  endtask

  task automatic apb_rd(input logic [7:0] a, output logic [31:0] d);
    psel = 1; pwrite = 0; penable = 0; paddr = a;
    @(negedge clk) penable = 1;
    #1 d = prdata;
    @(negedge clk) begin psel = 0; penable = 0; end
  endtask

  // model of one write
  task automatic model_wr(input logic [7:0] a, input logic [31:0] d);
    logic [7:0] n = d[7:0];
    bit ok = n < 8'(NP);
    case (a)
      8'h00: begin if (ok) m_out[n[4:0]] = 1'b1; m_idx = n; end
      8'h04: begin if (ok) m_out[n[4:0]] = 1'b0; m_idx = n; end
      8'h08: begin if (ok) m_out[n[4:0]] = ~m_out[n[4:0]]; m_idx = n; end
      8'h20: m_out = d;
      8'h30: m_idx = n;
      8'h38: if (ok) m_mode[n[4:0]] = d[25:24];
      8'h3C: begin if (ok) begin m_itype[n[4:0]] = d[19:17]; m_ien[n[4:0]] = d[16]; end m_idx = n; end
      default: ;
    endcase
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    apb_wr(a, d);
    model_wr(a, d);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    logic [7:0] ops [7] = '{8'h00, 8'h04, 8'h08, 8'h20, 8'h30, 8'h38, 8'h3C};
    void'($urandom(32'h1234_5678));
    for (int i = 0; i < NP; i++) begin m_mode[i] = 0; m_itype[i] = 0; m_ien[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    chk("R1 out", gpio_out, 0);
    chk("R1 dir", gpio_dir, 0);
    apb_rd(8'h34, rd); chk("R1 status", rd, 0);
    chk("R12 pready", 32'(pready), 1);
    chk("R12 pslverr", 32'(pslverr), 0);

    // R2 R3 R4 directed
    wr(8'h00, 32'h0000_0005); chk("R2 set", gpio_out, m_out);
    wr(8'h00, 32'hFFFF_FF1F); chk("R2 set pin31 junk bits", gpio_out, m_out);
    wr(8'h04, 32'h0000_0005); chk("R3 clr", gpio_out, m_out);
    wr(8'h08, 32'h0000_0000); chk("R4 tog up", gpio_out, m_out);
    wr(8'h08, 32'h0000_0000); chk("R4 tog down", gpio_out, m_out);

    // R7 word load
    wr(8'h20, 32'hA5C3_0F96); chk("R7 word", gpio_out, 32'hA5C3_0F96);

    // R5 out-of-range numbers
    wr(8'h00, 32'h0000_0020); chk("R5 set 32 ignored", gpio_out, 32'hA5C3_0F96);
    wr(8'h04, 32'h0000_00FF); chk("R5 clr 255 ignored", gpio_out, 32'hA5C3_0F96);
    wr(8'h38, 32'h0100_0021); chk("R5 mode 33 ignored", gpio_dir, 0);
    apb_rd(8'h34, rd); chk("R5 index still stored", rd, 32'h0000_00FF);

    // R10 modes
    wr(8'h38, 32'h0100_0003); chk("R10 mode 01 drives", gpio_dir, 32'h8);
    wr(8'h38, 32'h0200_0003); chk("R10 mode 10 input", gpio_dir, 0);
    wr(8'h38, 32'h0300_0004); chk("R10 mode 11 input", gpio_dir, 0);
    wr(8'h38, 32'h0100_001F); chk("R10 pin31 out", gpio_dir, dir_exp());

    // R8 mode write leaves index; R11 + R9
    wr(8'h30, 32'h0000_0004);
    wr(8'h38, 32'h0100_0009);
    apb_rd(8'h34, rd); chk("R8 mode no index change", rd, stat_exp(8'd4));
    wr(8'h3C, 32'h000F_0009);
    apb_rd(8'h34, rd); chk("R11 int cfg", rd, stat_exp(8'd9));
    chk("R9 packed bits", rd, 32'h010F_0009 | (32'(m_out[9]) << 8));

    // R12 setup-only cycle changes nothing
    psel = 1; pwrite = 1; penable = 0; paddr = 8'h20; pwdata = 32'h0;
    @(negedge clk) begin psel = 0; pwrite = 0; end
    chk("R12 setup only", gpio_out, m_out);
    apb_rd(8'h20, rd); chk("R12 wo read 0", rd, 0);
    apb_rd(8'h44, rd); chk("R12 unmapped read 0", rd, 0);

    // R6 synchroniser latency
    gpio_in = 32'h1357_9BDF;
    apb_rd(8'h10, rd); chk("R6 old value", rd, 0);
    apb_rd(8'h10, rd); chk("R6 new value", rd, 32'h1357_9BDF);
    m_in = gpio_in;

    // random mix
    for (int k = 0; k < 400; k++) begin
      int sel = $urandom_range(0, 9);
      logic [31:0] d = $urandom;
      d[7:0] = 8'($urandom_range(0, 39));
      if (sel < 7) begin
        wr(ops[sel], d);
        chk("R2 R3 R4 R7 random out", gpio_out, m_out);
        chk("R10 random dir", gpio_dir, dir_exp());
      end else if (sel == 7) begin
        apb_rd(8'h34, rd); chk("R9 random status", rd, stat_exp(m_idx));
      end else if (sel == 8) begin
        gpio_in = $urandom;
        repeat (3) @(negedge clk);
        m_in = gpio_in;
        apb_rd(8'h10, rd); chk("R6 random pins", rd, m_in);
      end else begin
        apb_rd(8'h34, rd); chk("R8 random index", {24'b0, rd[7:0]}, {24'b0, m_idx});
      end
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule